// File: doc/BRIEF.md
# SCSI Arbitration and Selection Sequencer

This block runs the initiator side of a full arbitration followed by a selection on an 8-bit SCSI bus. Software, or a controller above it, pulses `start`. The block then waits for the bus to go free. It bids with its own ID and checks for stronger bidders after a programmable delay. If it loses, it retries on its own at every later bus-free period until it wins. Once it has won, it selects a target and either becomes connected or gives up after a programmable time-out.

All bus outputs are active-high enables for open-collector drivers. The `*_in` pins carry the wired bus as seen by a receiver, including this block's own drive. Priority follows data-bit number, so ID 7 is the strongest. The results are kept in four sticky flags: lost, won, function complete and selection time-out.

The state machine has five states:
- `S_IDLE`: nothing is pending.
- `S_WAIT_FREE`: waiting for the bus to go free.
- `S_ARB`: bidding.
- `S_SEL`: selecting the target.
- `S_CONN`: connected to the target.

The transitions are:
- IDLE→WAIT_FREE on an accepted start.
- WAIT_FREE→ARB on bus free.
- ARB→WAIT_FREE on a loss.
- ARB→SEL on a win.
- SEL→CONN when the target raises BSY.
- SEL→IDLE on time-out.
- CONN→IDLE when the bus BSY drops.

Top module: `scsi_arbsel_seq`

## Requirements
- R1: A `start` pulse is accepted only in S_IDLE, and only with at least one bit set in `own_ids`. Starts at any other time are ignored. `busy` is high from the cycle after acceptance until the selection ends, either connected or timed out, and then clears by itself.
- R2: Arbitration begins only after `bsy_in` and `sel_in` have both been low on `settle_cnt`+1 consecutive clock edges. While the bus is busy, `bsy_oe` stays low.
- R3: During arbitration `bsy_oe` is high and `data_oe` carries exactly one bit. That bit is the highest-numbered bit set in `own_ids`, captured when the start is accepted.
- R4: The bid is held for `arb_delay`+1 cycles and then judged. If any bit of `data_in` above the own ID is set, the block releases BSY and its ID bit, sets `lost_flag`, and waits for the next bus free before bidding again. Set bits below the own ID have no effect.
- R5: If `sel_in` is seen high during arbitration, the block also loses, with the same release and retry as R4.
- R6: On a win `won_flag` is set. `sel_oe` then goes high with `data_oe` equal to the own ID bit OR the bit numbered `target_id`, and `bsy_oe` is released.
- R7: When `bsy_in` is seen high during selection, the block sets `func_done` and `connected`. At the same time it releases `sel_oe` and `data_oe`.
- R8: If the target never answers, `sel_oe` stays high for exactly `sel_limit`+1 cycles. The block then releases SEL and the data bits, sets `sel_timeout`, and returns to idle.
- R9: `connected` stays high until `bsy_in` is seen low, which returns the block to idle. A start while connected is ignored: the flags are kept and `busy` stays low.
- R10: The four flags are sticky. All four clear together in the cycle after a start is accepted, and reset clears them.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| own_ids | input | 8 | Own ID mask; the highest set bit is used |
| target_id | input | 3 | Target ID number |
| settle_cnt | input | CNT_W | Bus-free settle count |
| arb_delay | input | CNT_W | Cycles before the bid is judged |
| sel_limit | input | CNT_W | Selection time-out count |
| bsy_in | input | 1 | Bus BSY as received |
| sel_in | input | 1 | Bus SEL as received |
| data_in | input | 8 | Bus data as received |
| bsy_oe | output | 1 | BSY driver enable |
| sel_oe | output | 1 | SEL driver enable |
| data_oe | output | 8 | Data-bit driver enables |
| busy | output | 1 | Start accepted, sequence running |
| connected | output | 1 | Connected to the target |
| lost_flag | output | 1 | Arbitration was lost at least once |
| won_flag | output | 1 | Arbitration was won |
| func_done | output | 1 | Selection completed |
| sel_timeout | output | 1 | Selection timed out |

## Verification
The assertions assume the bus inputs reflect this block's own enables in the same cycle, since the bus is a wired OR that includes its drive. They also assume a target raises BSY only after it has seen SEL and its ID bit. The bench keeps to both assumptions. It models the bus as the OR of the block's enables, a rival device and a target. That target registers BSY one cycle after it sees itself selected, and it drops BSY only on command. Rival bids and rival SEL are applied only while the block is bidding, and they are removed before a selection is expected to finish.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
    localparam int BUS_W = 8;
    localparam int ID_W  = $clog2(BUS_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_FREE,
        S_ARB,
        S_SEL,
        S_CONN
    } seq_state_t;
endpackage

// File: rtl/seq_cyc_timer.sv
module seq_cyc_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (!hit)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/seq_id_prio.sv
module seq_id_prio
    import scsi_seq_pkg::*;
(
    input  logic [BUS_W-1:0] mask,
    output logic [ID_W-1:0]  idx,
    output logic             valid,
    output logic [BUS_W-1:0] above
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < BUS_W; i++)
            if (mask[i]) idx = ID_W'(i);
    end

    assign valid = |mask;

    for (genvar g = 0; g < BUS_W; g++) begin : g_above
        assign above[g] = (32'(g) > 32'(idx));
    end
endmodule

// File: rtl/scsi_arbsel_seq.sv
module scsi_arbsel_seq
    import scsi_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BUS_W-1:0] own_ids,
    input  logic [ID_W-1:0]  target_id,
    input  logic [CNT_W-1:0] settle_cnt,
    input  logic [CNT_W-1:0] arb_delay,
    input  logic [CNT_W-1:0] sel_limit,
    input  logic             bsy_in,
    input  logic             sel_in,
    input  logic [BUS_W-1:0] data_in,
    output logic             bsy_oe,
    output logic             sel_oe,
    output logic [BUS_W-1:0] data_oe,
    output logic             busy,
    output logic             connected,
    output logic             lost_flag,
    output logic             won_flag,
    output logic             func_done,
    output logic             sel_timeout
);
    seq_state_t state_q, state_d;

    logic [ID_W-1:0]  own_idx;
    logic             own_ok;
    logic [BUS_W-1:0] own_above;
    logic [BUS_W-1:0] own_bit_q, above_q, tgt_bit_q;
    logic             free_hit, arb_hit, tmo_hit;
    logic             accept, bus_free, arb_lose, arb_win;

    seq_id_prio u_prio (
        .mask  (own_ids),
        .idx   (own_idx),
        .valid (own_ok),
        .above (own_above)
    );

    seq_cyc_timer #(.W(CNT_W)) u_free_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != S_WAIT_FREE || bsy_in || sel_in),
        .limit (settle_cnt),
        .hit   (free_hit)
    );

    seq_cyc_timer #(.W(CNT_W)) u_arb_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != S_ARB),
        .limit (arb_delay),
        .hit   (arb_hit)
    );

    seq_cyc_timer #(.W(CNT_W)) u_sel_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != S_SEL),
        .limit (sel_limit),
        .hit   (tmo_hit)
    );

    assign accept   = start && own_ok && (state_q == S_IDLE);
    assign bus_free = free_hit && !bsy_in && !sel_in;
    assign arb_lose = (state_q == S_ARB) &&
                      (sel_in || (arb_hit && |(data_in & above_q)));
    assign arb_win  = (state_q == S_ARB) && !arb_lose && arb_hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (accept)   state_d = S_WAIT_FREE;
            S_WAIT_FREE: if (bus_free) state_d = S_ARB;
            S_ARB: begin
                if (arb_lose)     state_d = S_WAIT_FREE;
                else if (arb_win) state_d = S_SEL;
            end
            S_SEL: begin
                if (bsy_in)       state_d = S_CONN;
                else if (tmo_hit) state_d = S_IDLE;
            end
            S_CONN:      if (!bsy_in)  state_d = S_IDLE;
            default:                   state_d = S_IDLE;
        endcase
    end

    // State register, captured IDs and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            own_bit_q   <= '0;
            above_q     <= '0;
            tgt_bit_q   <= '0;
            lost_flag   <= 1'b0;
            won_flag    <= 1'b0;
            func_done   <= 1'b0;
            sel_timeout <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                own_bit_q   <= BUS_W'(1) << own_idx;
                above_q     <= own_above;
                tgt_bit_q   <= BUS_W'(1) << target_id;
                lost_flag   <= 1'b0;
                won_flag    <= 1'b0;
                func_done   <= 1'b0;
                sel_timeout <= 1'b0;
            end
            if (arb_lose) lost_flag <= 1'b1;
            if (arb_win)  won_flag  <= 1'b1;
            if (state_q == S_SEL && bsy_in) func_done <= 1'b1;
            if (state_q == S_SEL && !bsy_in && tmo_hit) sel_timeout <= 1'b1;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        bsy_oe    = 1'b0;
        sel_oe    = 1'b0;
        data_oe   = '0;
        busy      = 1'b0;
        connected = 1'b0;
        unique case (state_q)
            S_IDLE:      ;
            S_WAIT_FREE: busy = 1'b1;
            S_ARB: begin
                busy    = 1'b1;
                bsy_oe  = 1'b1;
                data_oe = own_bit_q;
            end
            S_SEL: begin
                busy    = 1'b1;
                sel_oe  = 1'b1;
                data_oe = own_bit_q | tgt_bit_q;
            end
            S_CONN:      connected = 1'b1;
            default:     ;
        endcase
    end

    // R3: a bid carries exactly one data bit
    p_one_bid_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_oe && !sel_oe) |-> ($countones(data_oe) == 1));

    // R6: SEL is only driven after a won arbitration
    p_sel_after_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_oe) |-> (won_flag && !bsy_oe));

    // R7: completion coincides with the connection and release of SEL
    p_done_conn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(func_done) |-> (connected && !sel_oe && data_oe == '0));

    // R8: time-out releases the bus and ends the sequence
    p_tmo_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_timeout) |-> (!sel_oe && data_oe == '0 && !busy));

    // R9: a start while connected does not launch a sequence
    p_no_start_conn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (connected && start) |=> !busy);

    // R7/R8: one selection cannot both finish and time out
    p_done_xor_tmo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(func_done && sel_timeout));
endmodule

// File: tb/scsi_arbsel_seq_bench.sv
module scsi_arbsel_seq_bench;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  own_ids = 8'h00;
    logic [2:0]  target_id = 3'd0;
    logic [CNT_W-1:0] settle_cnt = '0, arb_delay = '0, sel_limit = 16'd200;
    logic        ext_bsy = 1'b0, ext_sel = 1'b0;
    logic [7:0]  ext_data = 8'h00;
    logic        tgt_en = 1'b0, tgt_drop = 1'b0, tgt_bsy = 1'b0;
    logic        bsy_oe, sel_oe, busy, connected;
    logic        lost_flag, won_flag, func_done, sel_timeout;
    logic [7:0]  data_oe;
    logic        bsy_bus, sel_bus;
    logic [7:0]  data_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign bsy_bus  = bsy_oe | ext_bsy | tgt_bsy;
    assign sel_bus  = sel_oe | ext_sel;
    assign data_bus = data_oe | ext_data;

    // Target responder: raises BSY one cycle after seeing itself selected
    always @(posedge clk) begin
        if (tgt_drop)
            tgt_bsy <= 1'b0;
        else if (tgt_en && sel_oe && data_oe[target_id])
            tgt_bsy <= 1'b1;
    end

    scsi_arbsel_seq #(.CNT_W(CNT_W)) u_scsi_arbsel_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .own_ids(own_ids),
        .target_id(target_id), .settle_cnt(settle_cnt), .arb_delay(arb_delay),
        .sel_limit(sel_limit), .bsy_in(bsy_bus), .sel_in(sel_bus),
        .data_in(data_bus), .bsy_oe(bsy_oe), .sel_oe(sel_oe),
        .data_oe(data_oe), .busy(busy), .connected(connected),
        .lost_flag(lost_flag), .won_flag(won_flag), .func_done(func_done),
        .sel_timeout(sel_timeout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_bid(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!bsy_oe && n < 2000);
    endtask

    task automatic finish_conn(input string req);
        for (int i = 0; i < 2000 && !connected; i++) @(negedge clk);
        check(connected && func_done, req, {connected, func_done}, 3);
        check(!sel_oe && data_oe == 8'h00, req, data_oe, 0);
        check(!busy, {req, " busy cleared"}, busy, 0);
        @(negedge clk) tgt_drop = 1'b1;
        @(negedge clk) tgt_drop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check({bsy_oe, sel_oe, busy, connected, lost_flag, won_flag,
               func_done, sel_timeout} == 8'h00 && data_oe == 8'h00,
              "R11 reset state", {bsy_oe, sel_oe, busy, connected}, 0);
    endtask

    task automatic t_no_id();
        own_ids = 8'h00;
        pulse_start();
        repeat (5) @(negedge clk);
        check(!busy && !bsy_oe, "R1 start without own id ignored", busy, 0);
    endtask

    task automatic t_wait_free();
        int n, hi;
        own_ids = 8'h04; target_id = 3'd5; settle_cnt = 16'd3;
        arb_delay = 16'd2; sel_limit = 16'd200; tgt_en = 1'b1;
        ext_bsy = 1'b1;
        pulse_start();
        check(busy, "R1 busy after start", busy, 1);
        hi = 0;
        repeat (20) begin @(negedge clk); if (bsy_oe) hi++; end
        check(hi == 0, "R2 no bid while bus busy", hi, 0);
        ext_bsy = 1'b0;
        wait_bid(n);
        check(n == 4, "R2 settle before bid", n, 4);
        check(data_oe == 8'h04, "R3 bid carries own id", data_oe, 8'h04);
        n = 1;
        while (bsy_oe && n < 100) begin @(negedge clk); if (bsy_oe) n++; end
        check(n == 3, "R4 bid length", n, 3);
        check(sel_oe && data_oe == 8'h24 && won_flag && !bsy_oe,
              "R6 selection drive", data_oe, 8'h24);
        finish_conn("R7 completion");
        check(!connected, "R9 connected clears on BSY drop", connected, 0);
    endtask

    task automatic t_start_connected();
        own_ids = 8'h01; target_id = 3'd2; settle_cnt = 16'd0; arb_delay = 16'd0;
        pulse_start();
        for (int i = 0; i < 200 && !connected; i++) @(negedge clk);
        check(connected, "R9 connected", connected, 1);
        pulse_start();
        repeat (3) @(negedge clk);
        check(connected && !busy && func_done && won_flag,
              "R9 start ignored while connected", {busy, func_done}, 1);
        @(negedge clk) tgt_drop = 1'b1;
        @(negedge clk) tgt_drop = 1'b0;
        @(negedge clk);
        check(!connected, "R9 released", connected, 0);
    endtask

    task automatic t_multi_id();
        int n;
        own_ids = 8'h43; target_id = 3'd3; settle_cnt = 16'd1; arb_delay = 16'd1;
        pulse_start();
        check(!func_done && !won_flag, "R10 flags cleared on start", func_done, 0);
        wait_bid(n);
        check(data_oe == 8'h40, "R3 highest own id", data_oe, 8'h40);
        for (int i = 0; i < 50 && !sel_oe; i++) @(negedge clk);
        check(data_oe == 8'h48, "R6 select id pair", data_oe, 8'h48);
        finish_conn("R7 completion multi");
    endtask

    task automatic t_lost_prio();
        int n, hi;
        own_ids = 8'h10; target_id = 3'd1; settle_cnt = 16'd1; arb_delay = 16'd4;
        // lower contender has no effect
        pulse_start();
        wait_bid(n);
        ext_bsy = 1'b1; ext_data = 8'h08;
        for (int i = 0; i < 50 && !sel_oe; i++) @(negedge clk);
        ext_bsy = 1'b0; ext_data = 8'h00;
        check(won_flag && !lost_flag, "R4 lower id ignored", lost_flag, 0);
        finish_conn("R7 after lower contender");
        // higher contender wins
        pulse_start();
        wait_bid(n);
        ext_bsy = 1'b1; ext_data = 8'h40;
        for (int i = 0; i < 50 && bsy_oe; i++) @(negedge clk);
        check(lost_flag && !won_flag && data_oe == 8'h00 && !bsy_oe,
              "R4 higher id loses", {lost_flag, won_flag}, 2);
        hi = 0;
        repeat (10) begin @(negedge clk); if (bsy_oe) hi++; end
        check(hi == 0 && busy, "R4 waits for next bus free", hi, 0);
        ext_bsy = 1'b0; ext_data = 8'h00;
        finish_conn("R4 retry completes");
        check(lost_flag && won_flag, "R4 both flags after retry",
              {lost_flag, won_flag}, 3);
    endtask

    task automatic t_lost_sel();
        int n;
        own_ids = 8'h80; target_id = 3'd6; settle_cnt = 16'd2; arb_delay = 16'd6;
        pulse_start();
        wait_bid(n);
        ext_sel = 1'b1;
        repeat (2) @(negedge clk);
        check(!bsy_oe && lost_flag && !won_flag, "R5 SEL seen during bid",
              {bsy_oe, lost_flag}, 1);
        repeat (4) @(negedge clk);
        ext_sel = 1'b0;
        finish_conn("R5 retry completes");
    endtask

    task automatic t_timeout();
        int n;
        own_ids = 8'h02; target_id = 3'd0; settle_cnt = 16'd0; arb_delay = 16'd0;
        sel_limit = 16'd50; tgt_en = 1'b0;
        pulse_start();
        for (int i = 0; i < 100 && !sel_oe; i++) @(negedge clk);
        n = 0;
        while (sel_oe && n < 500) begin n++; @(negedge clk); end
        check(n == 51, "R8 selection window", n, 51);
        check(sel_timeout && !func_done && !busy && !connected && data_oe == 8'h00,
              "R8 time-out release", {sel_timeout, func_done}, 2);
        tgt_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_id();
        t_wait_free();
        t_multi_id();
        t_start_connected();
        t_lost_prio();
        t_lost_sel();
        t_timeout();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule